// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous request port and an 8192 x 8 asynchronous static RAM that shares one bidirectional data bus. Each accepted request becomes one complete memory cycle: the controller latches the address (and write data), drives the active-low chip-select, output-enable and write-strobe lines in the right order, holds each phase for a fixed number of clock cycles, and reports completion with a one-cycle acknowledge. Reads also return the sampled byte together with a one-cycle valid pulse.

All memory timing limits are given as parameters in nanoseconds together with the clock period in picoseconds. The controller converts each one to whole clock cycles by rounding up, with a floor of one cycle, and then derives the phase lengths from them. The data bus is split into an output value, a drive enable and an input value, so that the pad or the test model forms the shared bus outside this block.

Top module: `sram_bus_ctl`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, the next cycle shows `mem_ce_n`, `mem_oe_n` and `mem_we_n` high, `mem_dq_oe` low, and `req_ack` and `rd_valid` low.
- R2: A read (`req_write` = 0) holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for exactly RD cycles, RD being the largest of the address access, output-enable access and read cycle times in cycles; the byte on `mem_dq_in` at the end of that window appears on `rd_data`.
- R3: A write (`req_write` = 1) holds `mem_ce_n` and `mem_we_n` low with `mem_oe_n` high for exactly WP cycles, WP being the larger of the write pulse and data setup times in cycles, with `mem_dq_oe` high and the write data on `mem_dq_out` from the first cycle of that pulse.
- R4: After the write strobe rises, address and write data stay driven for exactly WR cycles, WR being the larger of the recovery time in cycles and the write cycle time in cycles minus WP; `req_ack` follows in the next cycle, WP + WR + 1 cycles after the request cycle.
- R5: `mem_dq_oe` is never high while `mem_oe_n` is low, and after `mem_oe_n` rises the bus is not driven for at least OD cycles, OD being the output turn-off time in cycles.
- R6: `mem_addr` does not change while `mem_ce_n` is low or while write data is driven.
- R7: A `req_valid` pulse that arrives while an access is in progress is ignored: it starts no memory cycle and writes nothing.
- R8: `req_ack` is a one-cycle pulse, given RD + OD + 1 cycles after a read request and WP + WR + 1 after a write request; `rd_valid` pulses in the same cycle as `req_ack` for reads only.
- R9: Each timing parameter maps to max(1, ceil(ns * 1000 / CLK_PS)) cycles; at the 8 ns default clock this gives RD = 19, OD = 5, WP = 13 and WR = 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | One-cycle request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` as fresh |
| rd_data | output | 8 | Last byte read |
| mem_addr | output | 13 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data returned from the memory |

## Verification
The assertions take for granted that `req_valid` is a single-cycle pulse and that reset is held for at least one edge before any request, so the edge-detecting checks start from strobes that are high. The bench drives every request as a one-cycle pulse on the falling edge, including the pulse it deliberately lands in the middle of a write, and its memory model only returns correct data once the strobes have been low for the access time and keeps driving for the turn-off time, so both short windows and early bus drive show up as wrong data or as a contention report.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACT,
    ST_RD_OFF,
    ST_WR_ACT,
    ST_WR_REC
  } seq_st_t;

  // whole cycles covering a time in ns, never below one
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // recovery window: own minimum, stretched so pulse + recovery covers the cycle time
  function automatic int unsigned rec_len(int unsigned wr, int unsigned wc, int unsigned wp);
    return max2(wr, (wc > wp) ? wc - wp : 0);
  endfunction

endpackage

// File: rtl/sram_bus_timer.sv
module sram_bus_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sram_bus_seq.sv
module sram_bus_seq
  import sram_bus_pkg::*;
#(
  parameter int CW     = 5,
  parameter int RD_LEN = 19,
  parameter int OD_LEN = 5,
  parameter int WP_LEN = 13,
  parameter int WR_LEN = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          start_acc,
  output logic          cap_rd,
  output logic          fin,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          drv,
  output logic          ack,
  output logic          rd_vld
);
  seq_st_t st, nxt;

  always_comb begin
    nxt       = st;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    start_acc = 1'b0;
    cap_rd    = 1'b0;
    fin       = 1'b0;
    unique case (st)
      ST_IDLE: if (req_valid) begin
        start_acc = 1'b1;
        tmr_load  = 1'b1;
        if (req_write) begin
          nxt     = ST_WR_ACT;
          tmr_val = CW'(WP_LEN - 1);
        end else begin
          nxt     = ST_RD_ACT;
          tmr_val = CW'(RD_LEN - 1);
        end
      end
      ST_RD_ACT: if (tmr_done) begin
        nxt      = ST_RD_OFF;
        cap_rd   = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CW'(OD_LEN - 1);
      end
      ST_RD_OFF: if (tmr_done) begin
        nxt = ST_IDLE;
        fin = 1'b1;
      end
      ST_WR_ACT: if (tmr_done) begin
        nxt      = ST_WR_REC;
        tmr_load = 1'b1;
        tmr_val  = CW'(WR_LEN - 1);
      end
      ST_WR_REC: if (tmr_done) begin
        nxt = ST_IDLE;
        fin = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // strobes come straight from flops, decoded from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ce_n   <= 1'b1;
      oe_n   <= 1'b1;
      we_n   <= 1'b1;
      drv    <= 1'b0;
      ack    <= 1'b0;
      rd_vld <= 1'b0;
    end else begin
      st     <= nxt;
      ce_n   <= !(nxt == ST_RD_ACT || nxt == ST_WR_ACT);
      oe_n   <= (nxt != ST_RD_ACT);
      we_n   <= (nxt != ST_WR_ACT);
      drv    <= (nxt == ST_WR_ACT || nxt == ST_WR_REC);
      ack    <= fin;
      rd_vld <= fin && (st == ST_RD_OFF);
    end
  end
endmodule

// File: rtl/sram_bus_dpath.sv
module sram_bus_dpath #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_acc,
  input  logic          cap_rd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_data    <= '0;
    end else begin
      if (start_acc) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (cap_rd) rd_data <= mem_dq_in;
    end
  end
endmodule

// File: rtl/sram_bus_ctl.sv
module sram_bus_ctl
  import sram_bus_pkg::*;
#(
  parameter int AW       = 13,
  parameter int DW       = 8,
  parameter int CLK_PS   = 8000,
  parameter int T_ACC_NS = 150,
  parameter int T_OE_NS  = 70,
  parameter int T_RC_NS  = 150,
  parameter int T_OD_NS  = 35,
  parameter int T_WP_NS  = 100,
  parameter int T_DS_NS  = 60,
  parameter int T_WC_NS  = 150,
  parameter int T_WR_NS  = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ack,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int ACC_CYC = ns_to_cyc(T_ACC_NS, CLK_PS);
  localparam int OE_CYC  = ns_to_cyc(T_OE_NS, CLK_PS);
  localparam int RC_CYC  = ns_to_cyc(T_RC_NS, CLK_PS);
  localparam int OD_CYC  = ns_to_cyc(T_OD_NS, CLK_PS);
  localparam int WPU_CYC = ns_to_cyc(T_WP_NS, CLK_PS);
  localparam int DS_CYC  = ns_to_cyc(T_DS_NS, CLK_PS);
  localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_PS);
  localparam int WRU_CYC = ns_to_cyc(T_WR_NS, CLK_PS);
  localparam int RD_CYC  = max2(ACC_CYC, max2(OE_CYC, RC_CYC));
  localparam int WP_CYC  = max2(WPU_CYC, DS_CYC);
  localparam int WR_CYC  = rec_len(WRU_CYC, WC_CYC, WP_CYC);
  localparam int MAX_CYC = max2(max2(RD_CYC, OD_CYC), max2(WP_CYC, WR_CYC));
  localparam int CW      = $clog2(MAX_CYC + 1);

  // named internal events, watched by the checker
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic          start_acc, cap_rd, seq_fin;

  sram_bus_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  sram_bus_seq #(
    .CW(CW), .RD_LEN(RD_CYC), .OD_LEN(OD_CYC), .WP_LEN(WP_CYC), .WR_LEN(WR_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .start_acc(start_acc), .cap_rd(cap_rd), .fin(seq_fin),
    .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .drv(mem_dq_oe),
    .ack(req_ack), .rd_vld(rd_valid)
  );

  sram_bus_dpath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .start_acc(start_acc), .cap_rd(cap_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .rd_data(rd_data)
  );
endmodule

// File: rtl/sram_bus_ctl_chk.sv
module sram_bus_ctl_chk #(
  parameter int AW     = 13,
  parameter int OD_LEN = 5,
  parameter int WP_LEN = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr,
  input logic          req_ack,
  input logic          rd_valid,
  input logic          seq_fin
);
  int unsigned oe_hi;
  int unsigned we_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_hi <= OD_LEN;
      we_lo <= 0;
    end else begin
      if (!mem_oe_n)           oe_hi <= 0;
      else if (oe_hi < OD_LEN) oe_hi <= oe_hi + 1;
      if (mem_we_n)            we_lo <= 0;
      else if (we_lo < WP_LEN) we_lo <= we_lo + 1;
    end
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ack && !rd_valid));

  // R2
  rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));

  // R3
  wr_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  // R3
  wp_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_lo >= WP_LEN));

  // R5
  turn_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (oe_hi >= OD_LEN));

  // R6
  addr_ce_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R4
  addr_drv_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_addr));

  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  // R8
  ack_src_chk: assert property (@(posedge clk) disable iff (rst)
    seq_fin |=> req_ack);

  // R8
  rdv_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> req_ack);
endmodule

bind sram_bus_ctl sram_bus_ctl_chk #(
  .AW(AW), .OD_LEN(OD_CYC), .WP_LEN(WP_CYC)
) u_chk (
  .clk(clk), .rst(rst), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr),
  .req_ack(req_ack), .rd_valid(rd_valid), .seq_fin(seq_fin)
);

// File: tb/sim_sram_bus_ctl.sv
module sim_sram_bus_ctl;
  // bench's own restatement of the cycle arithmetic (R9)
  function automatic int cyc8(int ns);
    int q;
    q = (ns * 1000) / 8000;
    if (q * 8000 < ns * 1000) q = q + 1;
    if (q == 0) q = 1;
    return q;
  endfunction

  localparam int ACC_B = cyc8(150);
  localparam int OEA_B = cyc8(70);
  localparam int OD_B  = cyc8(35);
  localparam int WPB_B = cyc8(100);
  localparam int DSB_B = cyc8(60);
  localparam int RD_B  = (ACC_B > OEA_B) ? ((ACC_B > cyc8(150)) ? ACC_B : cyc8(150)) : OEA_B;
  localparam int WP_B  = (WPB_B > DSB_B) ? WPB_B : DSB_B;
  localparam int WR_B  = (cyc8(150) - WP_B > cyc8(0)) ? cyc8(150) - WP_B : cyc8(0);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ack, rd_valid;
  logic [7:0]  rd_data;
  logic [12:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int n_vec = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  sram_bus_ctl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // memory model: 64 bytes indexed by the low address bits
  logic [7:0] mem [64];
  int rd_lo = 0;
  int wr_lo = 0;
  int hz    = 0;
  logic [7:0] wr_pend;
  logic [5:0] wr_idx;
  logic [12:0] addr_q;
  bit hold_q = 1'b0;

  initial for (int i = 0; i < 64; i++) mem[i] = 8'h00;

  always @(posedge clk) begin
    if (!mem_ce_n && !mem_oe_n) rd_lo <= rd_lo + 1; else rd_lo <= 0;
    if (!mem_oe_n) hz <= OD_B; else if (hz > 0) hz <= hz - 1;
    if (!mem_ce_n && !mem_we_n) begin
      wr_lo   <= wr_lo + 1;
      wr_pend <= mem_dq_out;
      wr_idx  <= mem_addr[5:0];
    end else begin
      if (wr_lo >= WP_B) mem[wr_idx] <= wr_pend;
      wr_lo <= 0;
    end
    addr_q <= mem_addr;
    hold_q <= !mem_ce_n || mem_dq_oe;
  end

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && rd_lo >= ACC_B - 1) ? mem[mem_addr[5:0]] : 8'hEE;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus monitors
  always @(negedge clk) if (!rst) begin
    if (mem_dq_oe) chk(!(!mem_oe_n || hz > 0), "R5 bus driven while memory may drive", 1, 0);
    if (hold_q && (!mem_ce_n || mem_dq_oe))
      chk(mem_addr == addr_q, "R6 address moved during access", mem_addr, addr_q);
  end

  task automatic issue(bit wr, logic [12:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_oe, "R1 drive off in reset", mem_dq_oe, 0);
    chk(!req_ack && !rd_valid, "R1 ack/valid low in reset", {req_ack, rd_valid}, 0);
    rst = 1'b0;
  endtask

  task automatic t_write(logic [12:0] a, logic [7:0] d);
    int n = 0, wl = 0, first_drv = 0;
    issue(1'b1, a, d);
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        req_valid = 1'b0;
        first_drv = (mem_dq_oe && mem_dq_out == d && !mem_we_n);
      end
      if (!mem_we_n) wl++;
    end while (!req_ack && n < 200);
    chk(first_drv == 1, "R3 data driven from first pulse cycle", first_drv, 1);
    chk(wl == WP_B, "R3 R9 write pulse length", wl, WP_B);
    chk(n == WP_B + WR_B + 1, "R4 R9 write ack latency", n, WP_B + WR_B + 1);
    chk(!rd_valid, "R8 no rd_valid on write", rd_valid, 0);
    @(negedge clk);
    chk(!req_ack && !mem_dq_oe, "R8 ack single cycle after write", {req_ack, mem_dq_oe}, 0);
  endtask

  task automatic t_read(logic [12:0] a, logic [7:0] exp);
    int n = 0, ol = 0;
    issue(1'b0, a, 8'h00);
    do begin
      @(negedge clk);
      n++;
      if (n == 1) req_valid = 1'b0;
      if (!mem_oe_n) ol++;
    end while (!req_ack && n < 200);
    chk(ol == RD_B, "R2 R9 read strobe length", ol, RD_B);
    chk(n == RD_B + OD_B + 1, "R8 R9 read ack latency", n, RD_B + OD_B + 1);
    chk(rd_valid == 1'b1, "R8 rd_valid with ack", rd_valid, 1);
    chk(rd_data == exp, "R2 read data", rd_data, exp);
    @(negedge clk);
    chk(!req_ack && !rd_valid, "R8 pulses single cycle after read", {req_ack, rd_valid}, 0);
  endtask

  task automatic t_busy_ignore;
    int n = 0, starts = 0;
    issue(1'b1, 13'h0105, 8'h96);
    do begin
      @(negedge clk);
      n++;
      if (n == 1) req_valid = 1'b0;
      if (n == 3) begin req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0006; req_wdata = 8'h11; end
      if (n == 4) req_valid = 1'b0;
    end while (!req_ack && n < 200);
    chk(n == WP_B + WR_B + 1, "R7 busy write completes unchanged", n, WP_B + WR_B + 1);
    repeat (6) begin
      @(negedge clk);
      if (!mem_ce_n || req_ack) starts++;
    end
    chk(starts == 0, "R7 no extra cycle after ignored request", starts, 0);
    t_read(13'h0006, 8'h6C);
    t_read(13'h0105, 8'h96);
  endtask

  initial begin
    t_reset;
    t_write(13'h0001, 8'hA5);
    t_write(13'h1FC2, 8'h5A);
    t_write(13'h0A43, 8'hFF);
    t_write(13'h1FFF, 8'h3C);
    t_write(13'h0006, 8'h6C);
    t_read(13'h0001, 8'hA5);
    t_read(13'h1FC2, 8'h5A);
    t_read(13'h0A43, 8'hFF);
    t_read(13'h1FFF, 8'h3C);
    // read straight into a write: turnaround watched by the bus monitor (R5)
    t_write(13'h0A43, 8'h0F);
    t_read(13'h0A43, 8'h0F);
    t_busy_ignore;
    t_reset;
    t_read(13'h1FC2, 8'h5A);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule